// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-clock synchronous SRAM bank. It accepts a new read or write on every clock cycle, and it needs no idle cycle when the bus changes direction. On each rising edge it captures the address, the operation, the byte enables and the chip selects into a two-stage command pipeline. A read returns its word two enabled cycles after its address cycle. A write takes its data from the bus two enabled cycles after its address cycle, which is the same slot a read uses for its result. The written word then waits one further edge in a pending-write register before it reaches the array. A read that arrives during that window has the pending bytes merged over the array word, so it always sees the newest data.

A freeze input suspends the whole block: every pipeline register, the pending write, the array and the output keep their values, and the bus inputs are ignored. Three chip selects, two active-low and one active-high, allow depth expansion. The default word is 36 bits, made of four 9-bit bytes, and the depth is a parameter.

Top module: `nt_sram`

## Requirements
- R1: After synchronous reset `rvalid` is 0 and `rdata` is all zeros, and no operation is in flight.
- R2: While `freeze` is 1, all bus inputs are ignored and every internal register keeps its value, including the output and the array. The pipeline resumes from the same point once `freeze` returns to 0, counting only enabled edges.
- R3: A read issued on an enabled edge presents its word on `rdata` with `rvalid`=1 after the second following enabled edge.
- R4: On a write, `wdata` is sampled on the second enabled edge after the address edge. Byte i is bits [9i+8:9i]. Byte i is written only when `byte_en[i]` is 1, and the other bytes keep their old value.
- R5: An operation starts only when `sel_n0`=0, `sel_p1`=1 and `sel_n2`=0. Any other combination is a deselect: nothing is written and no data is returned.
- R6: When `start_n` is 1, no operation starts on that edge, whatever `rw_n` is. The matching output slot is invalid.
- R7: Reads and writes can alternate on consecutive edges with no wait cycle, and every read returns correct data.
- R8: A read of an address whose write is still pending returns the pending enabled bytes merged over the stored word.
- R9: In an output slot that belongs to a write, a deselect or an idle cycle, `rvalid` is 0 and `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | 1 suspends all state and ignores inputs |
| start_n | input | 1 | 0 starts an operation at this edge |
| rw_n | input | 1 | 1 = read, 0 = write |
| sel_n0 | input | 1 | Chip select, active low |
| sel_p1 | input | 1 | Chip select, active high |
| sel_n2 | input | 1 | Chip select, active low |
| addr | input | AW | Word address |
| byte_en | input | BYTES | Per-byte write enable, active high |
| wdata | input | WORD_W | Write data, sampled two enabled edges after the address |
| rdata | output | WORD_W | Read data, zero when invalid |
| rvalid | output | 1 | 1 when `rdata` carries read data |

## Verification
The bench drives several patterns:
- Isolated write-then-read pairs, which establish the latency. They also show that data is sampled in the correct slot.
- Partial byte masks over a known word, which show that only the enabled lanes change.
- A read placed one cycle after a write to the same address, with a full mask and with a partial mask. This pattern succeeds only if the pending write is forwarded and merged, not just committed in time.
- Reads and writes alternating on every cycle, which confirms zero turnaround.
- Each chip select dropped in turn, and cycles with `start_n` high. Each of these must leave the array untouched.
- Freeze windows placed over the address phase, the data phase and a valid output. These show that freeze stretches the pipeline rather than dropping or duplicating work.

// File: rtl/nt_sram_pkg.sv
`timescale 1ns/1ps
package nt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // All three selects must be at their active levels.
    function automatic logic chips_selected(input logic s_n0, input logic s_p1,
                                            input logic s_n2);
        return !s_n0 && s_p1 && !s_n2;
    endfunction

    // Operation launched at a capture edge.
    function automatic op_e decode_op(input logic go_n, input logic rd_not_wr,
                                      input logic selected);
        if (go_n || !selected) return OP_NONE;
        return rd_not_wr ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/nt_sram_cmd_pipe.sv
`timescale 1ns/1ps
module nt_sram_cmd_pipe
    import nt_sram_pkg::*;
#(
    parameter int AW  = 8,
    parameter int NB  = 4,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  op_e           in_op,
    input  logic [AW-1:0] in_addr,
    input  logic [NB-1:0] in_be,
    output op_e           out_op,
    output logic [AW-1:0] out_addr,
    output logic [NB-1:0] out_be
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{op: OP_NONE, addr: '0, be: '0};

    cmd_t head;
    cmd_t stage_q [LAT];

    always_comb begin
        head.op   = in_op;
        head.addr = in_addr;
        head.be   = in_be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) stage_q[s] <= CMD_IDLE;
        end else if (!hold) begin
            stage_q[0] <= head;
            for (int s = 1; s < LAT; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign out_op   = stage_q[LAT-1].op;
    assign out_addr = stage_q[LAT-1].addr;
    assign out_be   = stage_q[LAT-1].be;
endmodule

// File: rtl/nt_sram_store.sv
`timescale 1ns/1ps
module nt_sram_store #(
    parameter int DEPTH = 256,
    parameter int BW    = 9,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int W    = BW * NB
) (
    input  logic          clk,
    input  logic          hold,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NB-1:0] wbe,
    input  logic [W-1:0]  wword,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rword
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!hold && we) begin
            for (int b = 0; b < NB; b++) begin
                if (wbe[b]) mem[waddr][b*BW +: BW] <= wword[b*BW +: BW];
            end
        end
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/nt_sram_merge.sv
`timescale 1ns/1ps
module nt_sram_merge #(
    parameter int AW   = 8,
    parameter int BW   = 9,
    parameter int NB   = 4,
    localparam int W   = BW * NB
) (
    input  logic [W-1:0]  stored,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_addr,
    input  logic [NB-1:0] pend_be,
    input  logic [W-1:0]  pend_word,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  merged
);
    logic hit;
    assign hit = pend_vld && (pend_addr == rd_addr);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[b*BW +: BW] = (hit && pend_be[b]) ? pend_word[b*BW +: BW]
                                                        : stored[b*BW +: BW];
    end
endmodule

// File: rtl/nt_sram.sv
`timescale 1ns/1ps
module nt_sram
    import nt_sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = BYTE_W * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              start_n,
    input  logic              rw_n,
    input  logic              sel_n0,
    input  logic              sel_p1,
    input  logic              sel_n2,
    input  logic [AW-1:0]     addr,
    input  logic [BYTES-1:0]  byte_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    localparam int LAT = 2;

    op_e               issue_op;
    op_e               s2_op;
    logic [AW-1:0]     s2_addr;
    logic [BYTES-1:0]  s2_be;

    logic              pend_vld;
    logic [AW-1:0]     pend_addr;
    logic [BYTES-1:0]  pend_be;
    logic [WORD_W-1:0] pend_word;

    logic [WORD_W-1:0] stored_word;
    logic [WORD_W-1:0] fwd_word;

    assign issue_op = decode_op(start_n, rw_n, chips_selected(sel_n0, sel_p1, sel_n2));

    nt_sram_cmd_pipe #(.AW(AW), .NB(BYTES), .LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .hold     (freeze),
        .in_op    (issue_op),
        .in_addr  (addr),
        .in_be    (byte_en),
        .out_op   (s2_op),
        .out_addr (s2_addr),
        .out_be   (s2_be)
    );

    // The write data slot matches the read return slot. The captured word
    // waits here one edge before it commits to the array.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
            pend_word <= '0;
        end else if (!freeze) begin
            pend_vld <= (s2_op == OP_WRITE);
            if (s2_op == OP_WRITE) begin
                pend_addr <= s2_addr;
                pend_be   <= s2_be;
                pend_word <= wdata;
            end
        end
    end

    nt_sram_store #(.DEPTH(DEPTH), .BW(BYTE_W), .NB(BYTES)) u_store (
        .clk   (clk),
        .hold  (freeze),
        .we    (pend_vld),
        .waddr (pend_addr),
        .wbe   (pend_be),
        .wword (pend_word),
        .raddr (s2_addr),
        .rword (stored_word)
    );

    nt_sram_merge #(.AW(AW), .BW(BYTE_W), .NB(BYTES)) u_merge (
        .stored    (stored_word),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_be   (pend_be),
        .pend_word (pend_word),
        .rd_addr   (s2_addr),
        .merged    (fwd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (!freeze) begin
            rvalid <= (s2_op == OP_READ);
            rdata  <= (s2_op == OP_READ) ? fwd_word : '0;
        end
    end
endmodule

// File: rtl/nt_sram_chk.sv
`timescale 1ns/1ps
module nt_sram_chk #(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = BYTE_W * BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic              freeze,
    input logic              start_n,
    input logic              rw_n,
    input logic              sel_n0,
    input logic              sel_p1,
    input logic              sel_n2,
    input logic [AW-1:0]     addr,
    input logic [BYTES-1:0]  byte_en,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);
    logic rd_launch;
    logic other_launch;

    assign rd_launch    = !freeze && !start_n && rw_n && !sel_n0 && sel_p1 && !sel_n2;
    assign other_launch = !freeze && !rd_launch;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_launch ##1 !freeze ##1 !freeze |=> rvalid); // R3

    AST_NONREAD_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        other_launch ##1 !freeze ##1 !freeze |=> !rvalid); // R9

    AST_FREEZE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(rvalid) && $stable(rdata))); // R2

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0)); // R9
endmodule

bind nt_sram nt_sram_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .start_n (start_n),
    .rw_n    (rw_n),
    .sel_n0  (sel_n0),
    .sel_p1  (sel_p1),
    .sel_n2  (sel_n2),
    .addr    (addr),
    .byte_en (byte_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .rvalid  (rvalid)
);

// File: tb/tb_nt_sram.sv
`timescale 1ns/1ps
module tb_nt_sram;
    localparam int DEPTH = 256;
    localparam int BW    = 9;
    localparam int NB    = 4;
    localparam int W     = BW * NB;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [2:0] SEL_ON = 3'b010;  // {sel_n0, sel_p1, sel_n2}
    localparam logic [NB-1:0] ALL = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, freeze, start_n, rw_n, sel_n0, sel_p1, sel_n2;
    logic [AW-1:0] addr;
    logic [NB-1:0] byte_en;
    logic [W-1:0]  wdata, rdata;
    logic          rvalid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    nt_sram dut (
        .clk(clk), .rst(rst), .freeze(freeze), .start_n(start_n), .rw_n(rw_n),
        .sel_n0(sel_n0), .sel_p1(sel_p1), .sel_n2(sel_n2), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [W-1:0] pat(input int k);
        return W'(k) * 36'h1_0203_0405 + 36'h7_0000_0013;
    endfunction

    // Byte i is bits [9i+8:9i]; enabled lanes take the new word.
    function automatic logic [W-1:0] lanes(input logic [W-1:0] old_w,
                                           input logic [W-1:0] new_w,
                                           input logic [NB-1:0] be);
        logic [W-1:0] r = old_w;
        for (int b = 0; b < NB; b++) if (be[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
        return r;
    endfunction

    task automatic step(input logic ld_n, input logic wrn, input logic [2:0] sel,
                        input logic [AW-1:0] a, input logic [NB-1:0] be,
                        input logic [W-1:0] wd, input logic frz);
        start_n = ld_n; rw_n = wrn; {sel_n0, sel_p1, sel_n2} = sel;
        addr = a; byte_en = be; wdata = wd; freeze = frz;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [W-1:0] wd);
        step(1'b0, 1'b0, SEL_ON, a, be, wd, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] wd);
        step(1'b0, 1'b1, SEL_ON, a, '0, wd, 1'b0);
    endtask

    task automatic nop(input logic [W-1:0] wd);
        step(1'b1, 1'b1, SEL_ON, '0, '0, wd, 1'b0);
    endtask

    task automatic expect_out(input logic ev, input logic [W-1:0] ed, input string tag);
        n_chk++;
        if (rvalid !== ev || rdata !== ed) begin
            n_err++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    // full word write that settles into the array
    task automatic preload(input logic [AW-1:0] a, input logic [W-1:0] d);
        wr(a, ALL, '0); nop('0); nop(d); nop('0);
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
        rd(a, '0); nop('0); nop('0);
        expect_out(1'b1, d, tag);
    endtask

    task automatic t_reset();
        expect_out(1'b0, '0, "R1 reset state");
    endtask

    task automatic t_write_read();
        wr(8'd10, ALL, '0); nop('0); nop(pat(1));
        expect_out(1'b0, '0, "R9 write slot invalid");
        nop('0);
        rd(8'd10, '0); nop('0);
        expect_out(1'b0, '0, "R3 not one cycle early");
        nop('0);
        expect_out(1'b1, pat(1), "R3 R4 read after two edges");
    endtask

    task automatic t_bytes();
        preload(8'd20, pat(2));
        wr(8'd20, 4'b0101, '0); nop('0); nop(pat(3)); nop('0);
        read_expect(8'd20, lanes(pat(2), pat(3), 4'b0101), "R4 partial lanes 0101");
        wr(8'd20, 4'b1000, '0); nop('0); nop(pat(4)); nop('0);
        read_expect(8'd20, lanes(lanes(pat(2), pat(3), 4'b0101), pat(4), 4'b1000),
                    "R4 top lane only");
        wr(8'd20, 4'b0000, '0); nop('0); nop(pat(5)); nop('0);
        read_expect(8'd20, lanes(lanes(pat(2), pat(3), 4'b0101), pat(4), 4'b1000),
                    "R4 empty mask keeps word");
    endtask

    task automatic t_forward();
        preload(8'd30, pat(6));
        wr(8'd30, 4'b0011, '0); rd(8'd30, '0); nop(pat(7));
        expect_out(1'b0, '0, "R9 write slot before forward");
        nop('0);
        expect_out(1'b1, lanes(pat(6), pat(7), 4'b0011), "R8 merged pending lanes");
        wr(8'd31, ALL, '0); rd(8'd31, '0); nop(pat(8)); nop('0);
        expect_out(1'b1, pat(8), "R8 full pending word");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 4; i++) begin
            wr(AW'(40 + i), ALL, (i == 0) ? '0 : pat(20 + i - 1));
            if (i > 0) expect_out(1'b0, '0, "R7 write slot in alternation");
            rd(AW'(40 + i), '0);
            if (i > 0) expect_out(1'b1, pat(20 + i - 1), "R7 read in alternation");
        end
        nop(pat(23));
        expect_out(1'b0, '0, "R7 last write slot");
        nop('0);
        expect_out(1'b1, pat(23), "R7 R8 last read");
        nop('0);
    endtask

    task automatic t_deselect();
        logic [2:0] bad [3];
        bad[0] = 3'b110; bad[1] = 3'b000; bad[2] = 3'b011;
        preload(8'd50, pat(9));
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, bad[k], 8'd50, ALL, '0, 1'b0); nop('0); nop(pat(10 + k));
            expect_out(1'b0, '0, "R5 deselected write slot");
            nop('0);
            step(1'b0, 1'b1, bad[k], 8'd50, '0, '0, 1'b0); nop('0); nop('0);
            expect_out(1'b0, '0, "R5 deselected read slot");
        end
        read_expect(8'd50, pat(9), "R5 deselected writes had no effect");
    endtask

    task automatic t_idle();
        step(1'b1, 1'b0, SEL_ON, 8'd50, ALL, '0, 1'b0); nop('0); nop(pat(14));
        expect_out(1'b0, '0, "R6 idle with rw_n low");
        nop('0);
        step(1'b1, 1'b1, SEL_ON, 8'd50, '0, '0, 1'b0); nop('0); nop('0);
        expect_out(1'b0, '0, "R6 idle with rw_n high");
        read_expect(8'd50, pat(9), "R6 idle cycles wrote nothing");
    endtask

    task automatic t_freeze();
        nop('0);
        rd(8'd10, '0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, SEL_ON, 8'd10, ALL, pat(30), 1'b1);
            expect_out(1'b0, '0, "R2 frozen during read flight");
        end
        nop('0);
        expect_out(1'b0, '0, "R2 resumed, one edge left");
        nop('0);
        expect_out(1'b1, pat(1), "R2 read completes after enabled edges");
        step(1'b0, 1'b0, SEL_ON, 8'd10, ALL, pat(31), 1'b1);
        expect_out(1'b1, pat(1), "R2 valid output held");
        step(1'b0, 1'b1, SEL_ON, 8'd11, ALL, pat(31), 1'b1);
        expect_out(1'b1, pat(1), "R2 valid output still held");
        nop('0);
        expect_out(1'b0, '0, "R2 output moves on after freeze");
        nop('0);
        read_expect(8'd10, pat(1), "R2 frozen inputs not written");
        wr(8'd60, ALL, '0); nop('0);
        step(1'b1, 1'b1, SEL_ON, '0, '0, pat(32), 1'b1);
        nop(pat(33)); nop('0);
        read_expect(8'd60, pat(33), "R2 write data taken on enabled edge");
    endtask

    initial begin
        rst = 1'b1; freeze = 1'b0; start_n = 1'b1; rw_n = 1'b1;
        {sel_n0, sel_p1, sel_n2} = SEL_ON; addr = '0; byte_en = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_bytes();
        t_forward();
        t_alternate();
        t_deselect();
        t_idle();
        t_freeze();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule